// File: doc/BRIEF.md
# Sticky Sensor Fault Status Register

This block gathers the fault indications of a sensor's internal monitors into one 16-bit status word that a serial interface reads out. There are four fault bits. One reports an arithmetic-unit overflow. One reports a signal-processing self-test fault. One reports a configuration CRC failure. One reports a supply voltage fault. Each bit follows its own set and clear policy. The monitors, the CRC computation and the serial framing live outside the block. It receives their per-cycle events and conditions, a per-check activation bit for three of the checks, an autocalibration-active flag, a single-cycle read strobe and a synchronous chip reset.

Each bit is a small state machine. The overflow bit uses `STK_CLEAR`/`STK_HELD`. It enters `STK_HELD` on an enabled overflow event and returns to `STK_CLEAR` on a read, unless a new event arrives in that same cycle. The CRC and voltage bits use the same two states. They enter `STK_HELD` while their masked condition is present, and a read returns them to `STK_CLEAR` only when that condition is absent. The self-test bit uses `ST_IDLE`, `ST_TESTING` and `ST_WDOG_HALT`. A self-test start moves `ST_IDLE` to `ST_TESTING`. A self-test finish moves `ST_TESTING` back to `ST_IDLE`. A watchdog stop moves any state to `ST_WDOG_HALT`, and only a chip reset leaves that state.

The read port returns the word as it stood before any clear that the same read causes. Clearing takes effect on the clock edge that ends the strobe cycle.

Top module: `fsr_status_reg`

## Requirements
- R1: A chip reset clears all four fault bits on the next edge. A read after reset returns 0x0000.
- R2: An overflow event while overflow checking is enabled sets bit 5 from the next cycle on. A read clears bit 5 at the edge that ends the strobe.
- R3: An overflow event while overflow checking is disabled leaves bit 5 unchanged. Disabling the check does not clear a bit 5 that is already set.
- R4: The CRC bit (bit 3) and the voltage bit (bit 2) are set while their enabled fault condition is present. A read clears such a bit only if the condition is absent in the strobe cycle.
- R5: Once set, the CRC and voltage bits stay set after their condition goes away, until a read clears them.
- R6: While autocalibration is active, a CRC fault condition is ignored, whatever the CRC activation bit says.
- R7: A fault event or condition in the same cycle as a clearing read leaves the bit set.
- R8: A watchdog stop sets bit 4. Reads, self-test starts and self-test finishes do not clear it. Only a chip reset does.
- R9: Bit 4 reads 1 from the cycle after a self-test start until a self-test finish. A finishing self-test returns it to 0 and never sets it.
- R10: rd_data is 0x0000 when no strobe is present. During a strobe it carries the pre-clear status, with bits 15:6 and 1:0 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| chip_rst_i | input | 1 | Synchronous chip reset, active high |
| ovf_evt_i | input | 1 | Overflow event pulse from the arithmetic monitor |
| ovf_en_i | input | 1 | Activation of the overflow check |
| bist_start_i | input | 1 | Self-test start pulse |
| bist_done_i | input | 1 | Self-test finish pulse |
| wdog_stop_i | input | 1 | Watchdog stop event |
| crc_fail_i | input | 1 | Configuration CRC mismatch condition |
| crc_en_i | input | 1 | Activation of the CRC check |
| autocal_i | input | 1 | Autocalibration active; forces the CRC check off |
| vr_fail_i | input | 1 | Supply voltage fault condition |
| vr_en_i | input | 1 | Activation of the voltage check |
| rd_stb_i | input | 1 | Single-cycle status read strobe |
| rd_data_o | output | 16 | Status word, valid during the strobe cycle |

## Verification
A set caused by an event or condition becomes visible one cycle later, because one flop in each bit state machine captures it. The read data is combinational, so it is due in the strobe cycle itself. A clear caused by that read shows up on a read one cycle later. The bench drives inputs on the falling edge and samples rd_data 1 ns afterwards, before the next rising edge. It advances its reference model at the rising edge. Every comparison therefore sees the state produced by all edges before that cycle and none after it.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
    localparam int STATUS_W   = 16;
    localparam int BIT_VR     = 2;
    localparam int BIT_CRC    = 3;
    localparam int BIT_ST     = 4;
    localparam int BIT_OVF    = 5;
    localparam int NUM_LEVEL  = 2;

    typedef enum logic {
        STK_CLEAR,
        STK_HELD
    } sticky_state_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TESTING,
        ST_WDOG_HALT
    } selftest_state_e;

    // Status bit position of each level-held check: index 0 voltage, 1 CRC
    function automatic int level_bit_pos(input int idx);
        return (idx == 0) ? BIT_VR : BIT_CRC;
    endfunction
endpackage

// File: rtl/fsr_event_bit.sv
`timescale 1ns/1ps
// Sticky flag set by an enabled event pulse, cleared by a read.
module fsr_event_bit
    import fsr_pkg::*;
(
    input  logic clk_i,
    input  logic chip_rst_i,
    input  logic evt_i,
    input  logic enable_i,
    input  logic rd_i,
    output logic flag_o
);
    sticky_state_e state_q, state_d;
    logic          hit;

    assign hit = evt_i & enable_i;

    always_ff @(posedge clk_i) begin
        if (chip_rst_i) state_q <= STK_CLEAR;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STK_CLEAR: if (hit)               state_d = STK_HELD;
            STK_HELD:  if (rd_i && !hit)      state_d = STK_CLEAR;
            default:                          state_d = STK_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == STK_HELD);
    end
endmodule

// File: rtl/fsr_level_bit.sv
`timescale 1ns/1ps
// Sticky flag held while an enabled condition persists; a read clears it
// only once the condition is gone.
module fsr_level_bit
    import fsr_pkg::*;
(
    input  logic clk_i,
    input  logic chip_rst_i,
    input  logic cond_i,
    input  logic enable_i,
    input  logic rd_i,
    output logic flag_o
);
    sticky_state_e state_q, state_d;
    logic          active;

    assign active = cond_i & enable_i;

    always_ff @(posedge clk_i) begin
        if (chip_rst_i) state_q <= STK_CLEAR;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STK_CLEAR: if (active)            state_d = STK_HELD;
            STK_HELD:  if (rd_i && !active)   state_d = STK_CLEAR;
            default:                          state_d = STK_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == STK_HELD);
    end
endmodule

// File: rtl/fsr_selftest_bit.sv
`timescale 1ns/1ps
// Self-test flag: shows a running test, latches a watchdog stop until
// chip reset, and is never set by a test result.
module fsr_selftest_bit
    import fsr_pkg::*;
(
    input  logic clk_i,
    input  logic chip_rst_i,
    input  logic wdog_stop_i,
    input  logic bist_start_i,
    input  logic bist_done_i,
    output logic flag_o
);
    selftest_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (chip_rst_i) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wdog_stop_i) begin
            state_d = ST_WDOG_HALT;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (bist_start_i) state_d = ST_TESTING;
                ST_TESTING:   if (bist_done_i)  state_d = ST_IDLE;
                ST_WDOG_HALT:                   state_d = ST_WDOG_HALT;
                default:                        state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        flag_o = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/fsr_status_reg.sv
`timescale 1ns/1ps
module fsr_status_reg
    import fsr_pkg::*;
#(
    parameter int STATUS_W_P = STATUS_W
) (
    input  logic                  clk_i,
    input  logic                  chip_rst_i,
    input  logic                  ovf_evt_i,
    input  logic                  ovf_en_i,
    input  logic                  bist_start_i,
    input  logic                  bist_done_i,
    input  logic                  wdog_stop_i,
    input  logic                  crc_fail_i,
    input  logic                  crc_en_i,
    input  logic                  autocal_i,
    input  logic                  vr_fail_i,
    input  logic                  vr_en_i,
    input  logic                  rd_stb_i,
    output logic [STATUS_W_P-1:0] rd_data_o
);
    logic                  ovf_flag;
    logic                  st_flag;
    logic [NUM_LEVEL-1:0]  lvl_cond;
    logic [NUM_LEVEL-1:0]  lvl_en;
    logic [NUM_LEVEL-1:0]  lvl_flag;
    logic [STATUS_W_P-1:0] status_w;

    fsr_event_bit u_ovf (
        .clk_i      (clk_i),
        .chip_rst_i (chip_rst_i),
        .evt_i      (ovf_evt_i),
        .enable_i   (ovf_en_i),
        .rd_i       (rd_stb_i),
        .flag_o     (ovf_flag)
    );

    fsr_selftest_bit u_st (
        .clk_i        (clk_i),
        .chip_rst_i   (chip_rst_i),
        .wdog_stop_i  (wdog_stop_i),
        .bist_start_i (bist_start_i),
        .bist_done_i  (bist_done_i),
        .flag_o       (st_flag)
    );

    // index 0: supply voltage, index 1: CRC (masked by autocalibration)
    assign lvl_cond = {crc_fail_i, vr_fail_i};
    assign lvl_en   = {crc_en_i & ~autocal_i, vr_en_i};

    for (genvar g = 0; g < NUM_LEVEL; g++) begin : g_level
        fsr_level_bit u_lvl (
            .clk_i      (clk_i),
            .chip_rst_i (chip_rst_i),
            .cond_i     (lvl_cond[g]),
            .enable_i   (lvl_en[g]),
            .rd_i       (rd_stb_i),
            .flag_o     (lvl_flag[g])
        );
    end

    always_comb begin
        status_w          = '0;
        status_w[BIT_OVF] = ovf_flag;
        status_w[BIT_ST]  = st_flag;
        for (int i = 0; i < NUM_LEVEL; i++) begin
            status_w[level_bit_pos(i)] = lvl_flag[i];
        end
    end

    always_comb begin
        rd_data_o = rd_stb_i ? status_w : '0;
    end
endmodule

// File: rtl/fsr_status_reg_chk.sv
`timescale 1ns/1ps
module fsr_status_reg_chk
    import fsr_pkg::*;
#(
    parameter int W = STATUS_W
) (
    input logic         clk,
    input logic         chip_rst,
    input logic         ovf_evt,
    input logic         ovf_en,
    input logic         bist_start,
    input logic         wdog,
    input logic         crc_fail,
    input logic         crc_en,
    input logic         autocal,
    input logic         vr_fail,
    input logic         vr_en,
    input logic         rd,
    input logic [W-1:0] status
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        chip_rst |=> (status == '0));

    // R2
    ovf_sets_chk: assert property (@(posedge clk) disable iff (chip_rst)
        (ovf_evt && ovf_en) |=> status[BIT_OVF]);

    // R3
    ovf_masked_chk: assert property (@(posedge clk) disable iff (chip_rst)
        (!ovf_en && !status[BIT_OVF]) |=> !status[BIT_OVF]);

    // R4
    crc_read_hold_chk: assert property (@(posedge clk) disable iff (chip_rst)
        (rd && crc_fail && crc_en && !autocal) |=> status[BIT_CRC]);

    // R4
    vr_read_hold_chk: assert property (@(posedge clk) disable iff (chip_rst)
        (rd && vr_fail && vr_en) |=> status[BIT_VR]);

    // R5
    vr_sticky_chk: assert property (@(posedge clk) disable iff (chip_rst)
        (status[BIT_VR] && !rd) |=> status[BIT_VR]);

    // R5
    crc_sticky_chk: assert property (@(posedge clk) disable iff (chip_rst)
        (status[BIT_CRC] && !rd) |=> status[BIT_CRC]);

    // R6
    autocal_mask_chk: assert property (@(posedge clk) disable iff (chip_rst)
        (autocal && !status[BIT_CRC]) |=> !status[BIT_CRC]);

    // R7
    ovf_collide_chk: assert property (@(posedge clk) disable iff (chip_rst)
        (rd && ovf_evt && ovf_en && status[BIT_OVF]) |=> status[BIT_OVF]);

    // R8
    wdog_sets_chk: assert property (@(posedge clk) disable iff (chip_rst)
        wdog |=> status[BIT_ST]);

    // R9
    bist_shows_chk: assert property (@(posedge clk) disable iff (chip_rst)
        (bist_start && !status[BIT_ST]) |=> status[BIT_ST]);
endmodule

bind fsr_status_reg fsr_status_reg_chk #(.W(STATUS_W_P)) u_chk (
    .clk        (clk_i),
    .chip_rst   (chip_rst_i),
    .ovf_evt    (ovf_evt_i),
    .ovf_en     (ovf_en_i),
    .bist_start (bist_start_i),
    .wdog       (wdog_stop_i),
    .crc_fail   (crc_fail_i),
    .crc_en     (crc_en_i),
    .autocal    (autocal_i),
    .vr_fail    (vr_fail_i),
    .vr_en      (vr_en_i),
    .rd         (rd_stb_i),
    .status     (status_w)
);

// File: tb/fsr_status_reg_bench.sv
`timescale 1ns/1ps
module fsr_status_reg_bench;
    import fsr_pkg::*;
    localparam int W = STATUS_W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic chip_rst, ovf_evt, ovf_en, bist_start, bist_done, wdog;
    logic crc_fail, crc_en, autocal, vr_fail, vr_en, rd;
    logic [W-1:0] rd_data;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  m_ovf, m_crc, m_vr;
    int  m_st;   // 0 idle, 1 testing, 2 watchdog halt

    fsr_status_reg u_fsr_status_reg (
        .clk_i        (clk),
        .chip_rst_i   (chip_rst),
        .ovf_evt_i    (ovf_evt),
        .ovf_en_i     (ovf_en),
        .bist_start_i (bist_start),
        .bist_done_i  (bist_done),
        .wdog_stop_i  (wdog),
        .crc_fail_i   (crc_fail),
        .crc_en_i     (crc_en),
        .autocal_i    (autocal),
        .vr_fail_i    (vr_fail),
        .vr_en_i      (vr_en),
        .rd_stb_i     (rd),
        .rd_data_o    (rd_data)
    );

    function automatic logic [W-1:0] exp_word();
        logic [W-1:0] w;
        w = '0;
        w[BIT_OVF] = m_ovf;
        w[BIT_ST]  = (m_st != 0);
        w[BIT_CRC] = m_crc;
        w[BIT_VR]  = m_vr;
        return w;
    endfunction

    task automatic model_update();
        bit crc_act, vr_act;
        crc_act = crc_fail && crc_en && !autocal;
        vr_act  = vr_fail && vr_en;
        if (chip_rst) begin
            m_ovf = 0; m_crc = 0; m_vr = 0; m_st = 0;
        end else begin
            if (ovf_evt && ovf_en) m_ovf = 1; else if (rd) m_ovf = 0;
            if (crc_act) m_crc = 1; else if (rd) m_crc = 0;
            if (vr_act)  m_vr  = 1; else if (rd) m_vr  = 0;
            if (wdog) m_st = 2;
            else if (m_st == 0 && bist_start) m_st = 1;
            else if (m_st == 1 && bist_done)  m_st = 0;
        end
    endtask

    task automatic step(input string tag);
        logic [W-1:0] exp;
        #1;
        exp = rd ? exp_word() : '0;
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, exp);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic pulses_off();
        chip_rst = 0; ovf_evt = 0; bist_start = 0; bist_done = 0; wdog = 0;
        crc_fail = 0; vr_fail = 0; rd = 0;
    endtask

    task automatic rd_once(input string tag);
        rd = 1; step(tag); rd = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        pulses_off();
        chip_rst = 1; ovf_en = 1; crc_en = 1; vr_en = 1; autocal = 0;
        m_ovf = 0; m_crc = 0; m_vr = 0; m_st = 0;
        @(negedge clk);
        step("R1 reset");
        chip_rst = 0;
        rd_once("R1 read after reset");

        // R2: enabled overflow latches, read clears
        ovf_evt = 1; step("R2 event"); ovf_evt = 0;
        rd_once("R2 latched");
        rd_once("R2 cleared");

        // R3: disabled overflow ignored; disabling keeps latched bit
        ovf_en = 0; ovf_evt = 1; step("R3 masked event"); ovf_evt = 0;
        rd_once("R3 masked read");
        ovf_en = 1; ovf_evt = 1; step("R3 event"); ovf_evt = 0; ovf_en = 0;
        rd_once("R3 kept after disable");
        rd_once("R3 cleared");
        ovf_en = 1;

        // R4: CRC held while condition persists
        crc_fail = 1; step("R4 condition");
        rd_once("R4 first read");
        rd_once("R4 persists");
        crc_fail = 0;
        rd_once("R4 gone, returns pre-clear");
        rd_once("R4 cleared");

        // R5: voltage stays set without a read
        vr_fail = 1; step("R5 condition"); vr_fail = 0;
        for (int i = 0; i < 5; i++) step("R5 idle");
        rd_once("R5 sticky");
        rd_once("R5 cleared");

        // R6: autocalibration masks CRC
        autocal = 1; crc_fail = 1; step("R6 masked"); step("R6 masked");
        rd_once("R6 read");
        crc_fail = 0; autocal = 0;
        rd_once("R6 still clear");

        // R7: event collides with a clearing read
        ovf_evt = 1; step("R7 set"); 
        rd = 1; step("R7 collide"); rd = 0; ovf_evt = 0;
        rd_once("R7 kept");
        rd_once("R7 cleared");

        // R8: watchdog stop held until chip reset
        wdog = 1; step("R8 wdog"); wdog = 0;
        rd_once("R8 set");
        rd_once("R8 read does not clear");
        bist_start = 1; step("R8 start"); bist_start = 0;
        bist_done = 1; step("R8 done"); bist_done = 0;
        rd_once("R8 self-test does not clear");
        chip_rst = 1; step("R8 chip reset"); chip_rst = 0;
        rd_once("R8 reset clears");

        // R9: running self-test shows, finish never sets
        bist_done = 1; step("R9 stray done"); bist_done = 0;
        rd_once("R9 not set by finish");
        bist_start = 1; step("R9 start"); bist_start = 0;
        rd_once("R9 running");
        rd_once("R9 still running");
        bist_done = 1; step("R9 finish"); bist_done = 0;
        rd_once("R9 back to 0");

        // R10: no strobe gives 0, strobe gives pre-clear value
        ovf_evt = 1; vr_fail = 1; step("R10 set"); ovf_evt = 0; vr_fail = 0;
        step("R10 no strobe");
        rd_once("R10 pre-clear value");
        rd_once("R10 cleared");

        // Constrained random mix, checked against the model (R10 and all bits)
        for (int i = 0; i < 3000; i++) begin
            ovf_evt    = ($urandom % 6) == 0;
            ovf_en     = ($urandom % 4) != 0;
            bist_start = ($urandom % 20) == 0;
            bist_done  = ($urandom % 20) == 0;
            wdog       = ($urandom % 150) == 0;
            crc_fail   = ($urandom % 5) == 0;
            crc_en     = ($urandom % 4) != 0;
            autocal    = ($urandom % 5) == 0;
            vr_fail    = ($urandom % 5) == 0;
            vr_en      = ($urandom % 4) != 0;
            rd         = ($urandom % 3) == 0;
            chip_rst   = ($urandom % 250) == 0;
            step("R10 random");
        end
        pulses_off();
        step("R10 final");
        finish_run();
    end
endmodule